// File: doc/BRIEF.md
# Loopback Code Detector

This block watches a received serial bit stream for two repeating in-band control codes and keeps a single status flag that says whether the network loopback is in force. An activate code, a period-5 stream carrying one mark per period (`00001 00001 ...`), sets the flag once it has been seen without a break for a fixed persistence time. A release code, a period-3 stream carrying one mark per period (`001 001 ...`), clears the flag under the same rule. A remote-loopback request clears the flag at once.

Bits are delivered one at a time with a valid strobe. The persistence time is counted in valid bits, not clock cycles. The default parameter covers five seconds at a 1.544 Mb/s line rate and can be made small for simulation. The flag drives the loopback data path, which lies outside this block.

Top module: `loopcode_det`

## Requirements
- R1: After reset `nloop_act` is low and both persistence runs are empty.
- R2: While the flag is low, `nloop_act` rises on the clock edge that samples the `HOLD_BITS`-th consecutive valid bit matching the activate code. A bit matches a code of period P when it equals the valid bit P positions earlier and the last P valid bits, itself included, hold exactly one `1`. Bits from before reset count as `0`.
- R3: A valid bit that does not match the activate code restarts its run. Activation then needs a full `HOLD_BITS` further matching bits.
- R4: While the flag is high, `nloop_act` falls on the clock edge that samples the `HOLD_BITS`-th consecutive valid bit matching the release code (period 3). A non-matching valid bit restarts that run.
- R5: The release code has no effect while the flag is low. The flag stays low, and the release run stays empty.
- R6: The activate code has no effect while the flag is high. The flag stays high, and the activate run stays empty.
- R7: `rloop_act` high clears `nloop_act` on the next clock edge. This overrides a completing activation, and both runs are emptied.
- R8: A clock cycle with `bit_vld` low leaves the bit history, both runs and the flag unchanged, whatever `bit_in` carries.
- R9: Streams other than the two codes never set the flag. This covers all zeros, all ones, alternating bits and `0011` repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Received data bit, 1 = mark |
| rloop_act | input | 1 | Remote loopback request, clears the flag |
| nloop_act | output | 1 | Network loopback active |

## Verification
The bench first drives streams that are not codes: zeros, ones, alternating bits and a period-4 pair of marks. These show that the match needs both the period and the single-mark test. An activate run broken one bit short of completion separates a restarting run from a mere pause. Gaps in the valid strobe carrying marks show that the timer counts valid bits and not clock cycles. Release codes sent while the flag is low, activate codes sent while it is high, and a remote request landing on the completing bit show which input wins in each state.

// File: rtl/loopcode_pkg.sv
package loopcode_pkg;

  localparam int unsigned MAX_PERIOD = 16;

  // population count of a window of at most MAX_PERIOD bits
  function automatic int unsigned mark_count(input logic [MAX_PERIOD-1:0] win);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_PERIOD; i++) n += int'(win[i]);
    return n;
  endfunction

  // a window is in code phase when it carries exactly one mark
  function automatic logic single_mark(input logic [MAX_PERIOD-1:0] win);
    return mark_count(win) == 1;
  endfunction

  // width of a counter able to hold 0..limit
  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/lc_code_match.sv
module lc_code_match
  import loopcode_pkg::*;
#(
  parameter int unsigned PERIOD = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic bit_in,
  output logic hit
);
  localparam int unsigned P = (PERIOD < 2) ? 2 : PERIOD;

  logic [P-1:0]          hist_q;   // hist_q[0] newest, hist_q[P-1] oldest
  logic [P-1:0]          window;
  logic [MAX_PERIOD-1:0] window_ext;
  logic                  periodic;
  logic                  phase_ok;

  assign window     = {hist_q[P-2:0], bit_in};
  assign window_ext = MAX_PERIOD'(window);
  assign periodic   = (bit_in == hist_q[P-1]);
  assign phase_ok   = single_mark(window_ext);
  assign hit        = shift_en && periodic && phase_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) hist_q <= '0;
    else if (shift_en) hist_q <= window;
  end

endmodule

// File: rtl/lc_run_timer.sv
module lc_run_timer
  import loopcode_pkg::*;
#(
  parameter int unsigned HOLD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic hit,
  input  logic clr,
  output logic done
);
  localparam int unsigned W = cnt_width(HOLD);
  localparam logic [W-1:0] LAST = W'(HOLD - 1);

  logic [W-1:0] run_q;

  assign done = step && hit && !clr && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  run_q <= '0;
    else if (step) begin
      if (!hit || done) run_q <= '0;
      else              run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/loopcode_det.sv
module loopcode_det
  import loopcode_pkg::*;
#(
  parameter int unsigned ACT_PERIOD = 5,
  parameter int unsigned REL_PERIOD = 3,
  parameter int unsigned HOLD_BITS  = 7_720_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic rloop_act,
  output logic nloop_act
);
  localparam int unsigned NCODE = 2;   // 0: activate, 1: release

  logic [NCODE-1:0] code_hit;
  logic [NCODE-1:0] code_clr;
  logic [NCODE-1:0] code_done;
  logic             nloop_q;
  logic             act_hit, rel_hit;
  logic             act_done, rel_done;

  // activate run only counts while inactive, release run only while active
  assign code_clr[0] = nloop_q  || rloop_act;
  assign code_clr[1] = !nloop_q || rloop_act;

  for (genvar g = 0; g < NCODE; g++) begin : g_code
    localparam int unsigned PER = (g == 0) ? ACT_PERIOD : REL_PERIOD;

    lc_code_match #(.PERIOD(PER)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .shift_en(bit_vld),
      .bit_in  (bit_in),
      .hit     (code_hit[g])
    );

    lc_run_timer #(.HOLD(HOLD_BITS)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .step (bit_vld),
      .hit  (code_hit[g]),
      .clr  (code_clr[g]),
      .done (code_done[g])
    );
  end

  assign act_hit  = code_hit[0];
  assign rel_hit  = code_hit[1];
  assign act_done = code_done[0];
  assign rel_done = code_done[1];

  always_ff @(posedge clk) begin
    if (!rst_n || rloop_act) nloop_q <= 1'b0;
    else if (act_done)       nloop_q <= 1'b1;
    else if (rel_done)       nloop_q <= 1'b0;
  end

  assign nloop_act = nloop_q;

endmodule

// File: rtl/loopcode_det_chk.sv
module loopcode_det_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_vld,
  input logic rloop_act,
  input logic nloop_act,
  input logic act_done,
  input logic rel_done
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> !nloop_act);

  assert_set_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_done && !rloop_act) |=> nloop_act);

  assert_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nloop_act) |-> $past(act_done));

  assert_clear_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rel_done |=> !nloop_act);

  assert_fall_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nloop_act) |-> $past(rel_done || rloop_act));

  assert_no_release_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !nloop_act |-> !rel_done);

  assert_no_activate_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nloop_act |-> !act_done);

  assert_remote_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rloop_act |=> !nloop_act);

  assert_gap_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_vld && !rloop_act) |=> $stable(nloop_act));

endmodule

bind loopcode_det loopcode_det_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_vld  (bit_vld),
  .rloop_act(rloop_act),
  .nloop_act(nloop_act),
  .act_done (act_done),
  .rel_done (rel_done)
);

// File: tb/loopcode_det_tb_top.sv
`timescale 1ns/1ps
module loopcode_det_tb_top;
  localparam int unsigned HOLD = 12;
  localparam int MAXB = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_vld = 1'b0;
  logic bit_in = 1'b0;
  logic rloop_act = 1'b0;
  logic nloop_act;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit sent [0:MAXB-1];
  int n_sent = 0;
  bit exp_on = 0;
  int run_a = 0;
  int run_r = 0;

  always #10 clk = ~clk;   // 50 MHz

  loopcode_det #(.ACT_PERIOD(5), .REL_PERIOD(3), .HOLD_BITS(HOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
    .rloop_act(rloop_act), .nloop_act(nloop_act)
  );

  function automatic bit past_bit(int k);
    return (k < 0) ? 1'b0 : sent[k];
  endfunction

  // a bit belongs to a period-p code when it repeats the bit p earlier
  // and the last p bits carry a single mark
  function automatic bit is_code(int p);
    int last = n_sent - 1;
    int marks = 0;
    for (int k = 0; k < p; k++) marks += int'(past_bit(last - k));
    return (past_bit(last) == past_bit(last - p)) && (marks == 1);
  endfunction

  task automatic check(string req, bit got, bit want);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s: nloop_act=%0b expected %0b (bit %0d)", req, got, want, n_sent);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one clock cycle: apply, update the reference, check after the edge
  task automatic step(bit vld, bit b, bit rl, string req);
    @(negedge clk);
    bit_vld = vld; bit_in = b; rloop_act = rl;
    if (vld) begin
      sent[n_sent] = b;
      n_sent++;
    end
    if (rl) begin
      exp_on = 0; run_a = 0; run_r = 0;
    end else if (vld) begin
      if (!exp_on) begin
        run_a = is_code(5) ? run_a + 1 : 0;
        if (run_a == HOLD) begin exp_on = 1; run_a = 0; end
      end else begin
        run_r = is_code(3) ? run_r + 1 : 0;
        if (run_r == HOLD) begin exp_on = 0; run_r = 0; end
      end
    end
    @(posedge clk);
    #2;
    check(req, nloop_act, exp_on);
  endtask

  task automatic send_pat(bit [7:0] pat, int plen, int nbits, string req);
    for (int i = 0; i < nbits; i++) step(1'b1, pat[plen-1-(i % plen)], 1'b0, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #2;
    check("R1", nloop_act, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #2;
    check("R1", nloop_act, 1'b0);

    // R9: non-code streams never activate
    send_pat(8'b0, 1, 60, "R9");
    send_pat(8'b1, 1, 60, "R9");
    send_pat(8'b01, 2, 60, "R9");
    send_pat(8'b0011, 4, 60, "R9");
    check("R9", nloop_act, 1'b0);

    // R3: activate code broken one bit before completion
    send_pat(8'b00001, 5, 5 * 3, "R3");
    step(1'b1, 1'b1, 1'b0, "R3");
    send_pat(8'b00001, 5, 5 + HOLD - 2, "R3");
    check("R3", nloop_act, 1'b0);

    // R2 + R8: code with idle gaps carrying marks
    for (int i = 0; i < 5 * HOLD; i++) begin
      step(1'b1, (i % 5) == 4, 1'b0, "R2");
      if (i % 7 == 3) step(1'b0, 1'b1, 1'b0, "R8");
    end
    check("R2", nloop_act, 1'b1);

    // R6: activate code while active
    send_pat(8'b00001, 5, 40, "R6");
    check("R6", nloop_act, 1'b1);

    // R8: long gap holds the active state
    for (int i = 0; i < 30; i++) step(1'b0, i[0], 1'b0, "R8");
    check("R8", nloop_act, 1'b1);

    // R4: release code
    send_pat(8'b001, 3, 3 * HOLD + 6, "R4");
    check("R4", nloop_act, 1'b0);

    // R5: release code while inactive
    send_pat(8'b001, 3, 60, "R5");
    check("R5", nloop_act, 1'b0);

    // R7: remote request clears active state
    send_pat(8'b00001, 5, 5 * HOLD + 10, "R2");
    check("R2", nloop_act, 1'b1);
    step(1'b1, 1'b0, 1'b1, "R7");
    check("R7", nloop_act, 1'b0);

    // R7: remote request on the completing bit wins
    while (run_a != HOLD - 1) step(1'b1, is_code_next(), 1'b0, "R7");
    step(1'b1, is_code_next(), 1'b1, "R7");
    check("R7", nloop_act, 1'b0);
    send_pat(8'b00001, 5, 5 * HOLD, "R7");

    finish_run();
  end

  // next bit of the period-5 code, continuing the sent history
  function automatic bit is_code_next();
    return past_bit(n_sent - 5) ^ 1'b0 ? 1'b1 : (past_bit(n_sent - 1) ||
           past_bit(n_sent - 2) || past_bit(n_sent - 3) || past_bit(n_sent - 4)) ? 1'b0 : 1'b1;
  endfunction

endmodule